// File: doc/BRIEF.md
# Stacked Chip-Select Address Decoder

This block turns a memory-mapped read address into a chip select for one of four attached flash devices. The devices, called A1, A2, B1 and B2, are laid end to end in the address space starting at zero, in exactly that order. No base address is ever programmed. Each device has only a size register, written in units of 1024 bytes. A device's base is the sum of the sizes of all devices ahead of it in the fixed order.

A device whose size is zero takes no space and is skipped. Every device after it moves down to close the gap. For each address the block reports three things: a one-hot chip select with its 2-bit index, the address relative to the start of the chosen device, and a flag when the address lies at or beyond the end of the last region. The address decode is purely combinational. Only the size registers hold state.

Top module: `stacked_cs_decoder`

## Requirements
- R1: After reset every size register is zero, so every address decodes as out of range with no chip select asserted.
- R2: A size register is written on a rising clock edge while `cfgWe` is high. Byte offset 0x0 selects A1, 0x4 selects A2, 0x8 selects B1 and 0xC selects B2. A write whose offset has bit 1 or bit 0 set changes no register.
- R3: A size value N makes its region span N*1024 bytes.
- R4: A1 begins at address 0. A2, B1 and B2 each begin at the address where the region before them in that order ends.
- R5: A region of size zero is never selected, and the regions after it begin where the nearest nonzero region before it ends.
- R6: An address at or above the sum of all four sizes (times 1024) gives `outOfRange` = 1, `csSel` = 0, `devIdx` = 0 and `localAddr` = 0.
- R7: An address below the total asserts exactly one bit of `csSel` (bit 0 = A1, 1 = A2, 2 = B1, 3 = B2). `devIdx` carries the same number, and `outOfRange` = 0.
- R8: For an address in range, `localAddr` equals the address minus the base of the selected region.
- R9: Outputs follow `rdAddr` in the same cycle with no register in the path. A size write affects the decode from the clock edge that stores it, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the size registers |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Size register write enable |
| cfgOffset | input | 4 | Byte offset of the size register to write |
| cfgSizeKb | input | SIZE_W | Region size in 1024-byte units |
| rdAddr | input | ADDR_W | Read address to decode |
| csSel | output | 4 | One-hot chip select, bit 0 = A1 to bit 3 = B2 |
| devIdx | output | 2 | Index of the selected device |
| localAddr | output | ADDR_W | Address relative to the selected region's base |
| outOfRange | output | 1 | Address is at or beyond the mapped total |

## Verification
The hardest cases to reach are the ones where several regions are zero. In those cases a later device moves down onto the addresses an earlier device would have held, and region edges line up in ways no single-region test exposes. The stimulus writes size sets with zeros in the middle and zeros at the front, a set that fills the address space exactly, and a set whose total runs past the top of the address space.

For each size set, the bench sweeps every 1 KB page with several low-order offsets. It compares the outputs against a running sum of the sizes held in the bench. A misaligned write and a check just before a write edge show that the registers change only when and where they should.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam int NDEV      = 4;
  localparam int DEV_IDX_W = 2;
  localparam int KB_SHIFT  = 10;

  typedef enum logic [DEV_IDX_W-1:0] {
    DEV_A1 = 2'd0,
    DEV_A2 = 2'd1,
    DEV_B1 = 2'd2,
    DEV_B2 = 2'd3
  } devId_e;

  typedef struct packed {
    logic [NDEV-1:0] loadSize;
  } sizeStrobe_t;
endpackage

// File: rtl/csdec_ctrl.sv
module csdec_ctrl
  import csdec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [3:0]  cfgOffset,
  output sizeStrobe_t strobe
);
  logic wordAligned;
  logic [DEV_IDX_W-1:0] slot;

  assign wordAligned = (cfgOffset[1:0] == 2'b00);
  assign slot        = cfgOffset[3:2];

  always_comb begin
    strobe.loadSize = '0;
    if (cfgWe && wordAligned) strobe.loadSize[slot] = 1'b1;
  end

  // R2
  one_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.loadSize));

  // R2
  idle_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |-> (strobe.loadSize == '0));
endmodule

// File: rtl/csdec_datapath.sv
module csdec_datapath
  import csdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 22
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sizeStrobe_t          strobe,
  input  logic [SIZE_W-1:0]    wrSizeKb,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [NDEV-1:0]      csSel,
  output logic [DEV_IDX_W-1:0] devIdx,
  output logic [ADDR_W-1:0]    localAddr,
  output logic                 outOfRange
);
  localparam int PAGE_W = ADDR_W - KB_SHIFT;
  localparam int SUM_W  = SIZE_W + DEV_IDX_W;
  localparam int CMP_W  = ((SUM_W > PAGE_W) ? SUM_W : PAGE_W) + 1;

  logic [SIZE_W-1:0] sizeKb      [NDEV];
  logic [CMP_W-1:0]  regionBase  [NDEV];
  logic [CMP_W-1:0]  regionEnd   [NDEV];
  logic [NDEV-1:0]   hit;
  logic [CMP_W-1:0]  pageIdx;
  logic [CMP_W-1:0]  selBase;
  logic [PAGE_W-1:0] pageOff;

  assign pageIdx = CMP_W'(rdAddr[ADDR_W-1:KB_SHIFT]);

  for (genvar g = 0; g < NDEV; g++) begin : g_region
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  sizeKb[g] <= '0;
      else if (strobe.loadSize[g]) sizeKb[g] <= wrSizeKb;
    end

    if (g == 0) begin : g_first
      assign regionBase[g] = '0;
    end else begin : g_next
      assign regionBase[g] = regionEnd[g-1];
    end

    assign regionEnd[g] = regionBase[g] + CMP_W'(sizeKb[g]);
    assign hit[g] = (sizeKb[g] != '0) && (pageIdx >= regionBase[g])
                    && (pageIdx < regionEnd[g]);

    // R2
    hold_size_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.loadSize[g] |=> $stable(sizeKb[g]));

    // R5
    empty_never_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
      (sizeKb[g] == '0) |-> !csSel[g]);
  end

  assign outOfRange = (pageIdx >= regionEnd[NDEV-1]);

  always_comb begin
    devIdx  = '0;
    selBase = '0;
    for (int i = 0; i < NDEV; i++) begin
      if (hit[i]) begin
        devIdx  = DEV_IDX_W'(i);
        selBase = regionBase[i];
      end
    end
  end

  assign pageOff   = PAGE_W'(pageIdx - selBase);
  assign csSel     = hit;
  assign localAddr = outOfRange ? '0 : {pageOff, rdAddr[KB_SHIFT-1:0]};

  // R6
  oor_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    outOfRange |-> (csSel == '0 && devIdx == '0 && localAddr == '0));

  // R7
  in_range_one_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outOfRange |-> ($countones(csSel) == 1 && csSel[devIdx]));

  // R8
  offset_in_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outOfRange |-> (CMP_W'(localAddr[ADDR_W-1:KB_SHIFT]) < CMP_W'(sizeKb[devIdx])));
endmodule

// File: rtl/stacked_cs_decoder.sv
module stacked_cs_decoder
  import csdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [3:0]        cfgOffset,
  input  logic [SIZE_W-1:0] cfgSizeKb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [3:0]        csSel,
  output logic [1:0]        devIdx,
  output logic [ADDR_W-1:0] localAddr,
  output logic              outOfRange
);
  sizeStrobe_t strobe;

  csdec_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgOffset (cfgOffset),
    .strobe    (strobe)
  );

  csdec_datapath #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrSizeKb   (cfgSizeKb),
    .rdAddr     (rdAddr),
    .csSel      (csSel),
    .devIdx     (devIdx),
    .localAddr  (localAddr),
    .outOfRange (outOfRange)
  );
endmodule

// File: tb/stacked_cs_decoder_test.sv
`timescale 1ns/1ps
module stacked_cs_decoder_test;
  localparam int AW = 16;
  localparam int SW = 6;
  localparam int PAGES = 1 << (AW - 10);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [3:0]    cfgOffset = '0;
  logic [SW-1:0] cfgSizeKb = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [3:0]    csSel;
  logic [1:0]    devIdx;
  logic [AW-1:0] localAddr;
  logic          outOfRange;

  int checks = 0;
  int failures = 0;
  int sz [4] = '{0, 0, 0, 0};

  always #2.5 clk = ~clk;

  stacked_cs_decoder #(.ADDR_W(AW), .SIZE_W(SW)) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgOffset(cfgOffset),
    .cfgSizeKb(cfgSizeKb), .rdAddr(rdAddr), .csSel(csSel),
    .devIdx(devIdx), .localAddr(localAddr), .outOfRange(outOfRange)
  );

  task automatic writeSize(input logic [3:0] off, input int val);
    @(negedge clk);
    cfgWe = 1'b1; cfgOffset = off; cfgSizeKb = SW'(val);
    @(posedge clk);
    #1;
    cfgWe = 1'b0;
    if (off[1:0] == 2'b00) sz[off[3:2]] = val;
  endtask

  task automatic checkAddr(input string tag, input int addr);
    int base, total, expIdx, expLa;
    logic [3:0] expCs;
    logic expOor;
    rdAddr = AW'(addr);
    #1;
    base = 0; expCs = '0; expIdx = 0; expLa = 0;
    for (int i = 0; i < 4; i++) begin
      if (sz[i] != 0 && (addr >> 10) >= base && (addr >> 10) < base + sz[i]) begin
        expCs = 4'(1 << i); expIdx = i;
        expLa = addr - base * 1024;
      end
      base += sz[i];
    end
    total = base;
    expOor = ((addr >> 10) >= total);
    checks++;
    if (csSel !== expCs || devIdx !== 2'(expIdx) || outOfRange !== expOor
        || localAddr !== AW'(expLa)) begin
      failures++;
      $display("FAIL %s addr=%h got cs=%b idx=%0d oor=%b la=%h exp cs=%b idx=%0d oor=%b la=%h",
               tag, addr, csSel, devIdx, outOfRange, localAddr,
               expCs, expIdx, expOor, AW'(expLa));
    end
  endtask

  task automatic sweep(input string tag);
    for (int pg = 0; pg < PAGES; pg++) begin
      checkAddr(tag, pg * 1024);
      checkAddr(tag, pg * 1024 + 'h2A5);
      checkAddr(tag, pg * 1024 + 'h3FF);
    end
  endtask

  task automatic loadAll(input int a1, input int a2, input int b1, input int b2);
    writeSize(4'h0, a1);
    writeSize(4'h4, a2);
    writeSize(4'h8, b1);
    writeSize(4'hC, b2);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #12 rstN = 1'b1;
    @(negedge clk);
    sweep("R1 reset all out of range");

    // R9: a write takes effect at its edge, not before
    rdAddr = '0;
    @(negedge clk);
    cfgWe = 1'b1; cfgOffset = 4'h0; cfgSizeKb = SW'(1);
    #1;
    checkAddr("R9 before write edge", 0);
    @(posedge clk);
    #1;
    cfgWe = 1'b0; sz[0] = 1;
    checkAddr("R9 after write edge", 0);

    loadAll(16, 16, 16, 16);
    sweep("R4 R7 R8 equal regions fill space");
    loadAll(8, 0, 20, 4);
    sweep("R5 R6 middle empty region");

    // R2: misaligned offsets leave the registers unchanged
    writeSize(4'h1, 50);
    writeSize(4'h6, 50);
    writeSize(4'hB, 50);
    sweep("R2 misaligned write ignored");

    loadAll(0, 0, 0, 10);
    sweep("R5 only last region");
    loadAll(5, 3, 0, 0);
    sweep("R3 R6 kilobyte edges");
    loadAll(1, 1, 1, 1);
    sweep("R4 R8 single page regions");
    loadAll(40, 63, 7, 2);
    sweep("R7 R8 total past top");
    loadAll(0, 0, 0, 0);
    sweep("R6 all cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule